// File: doc/BRIEF.md
# Dual-Path Interrupt Request Controller

This block gathers level-held request lines from up to twenty peripheral sources and steers each one to a normal request output, a fast request output, or both. Each source sits at a fixed bit position. That position is the same in every register of both paths, so software can use a single mask constant for either path.

Each path has three registers:
- an enable register, where writing ones sets enable bits and a read returns the mask;
- a disable register, where writing ones clears enable bits;
- a status register showing the pending sources that are enabled in that path.

A shared raw view shows every pending source, whether enabled or not. Pending bits belong to the peripherals: the controller only observes them and never clears them. Bit 0 of the fast status register summarises all enabled requests in either path. A select register holds a source index and reports whether that source is pending. Software programs the enables over a small word-addressed register bus. The two request outputs drive the processor core directly, whatever masking the core applies internally.

Top module: `irqc_top`

## Requirements
- R1: The raw register (address 0) shows `src_i` at bit 1 (software interrupt) and at bits 2..19 except bit 15. Bits 0, 15 and 20..31 read as zero.
- R2: A write to an enable register (address 2 normal, 5 fast) sets each enable bit whose data bit is one. Zero data bits leave their enable bits unchanged. A read returns the current mask.
- R3: A write to a disable register (address 3 normal, 6 fast) clears each enable bit whose data bit is one. These registers read as zero.
- R4: Enable bits 0, 1 and 15, and bits 20 and above, can never be set. They read as zero.
- R5: A path's status register (address 1 normal, 4 fast) at bit n equals raw bit n AND that path's enable bit n. The two paths are independent.
- R6: Fast status bit 0 reads one exactly when any enabled source is pending in either path.
- R7: `irq_o` equals the OR of the normal status bits, one clock later. `fiq_o` equals the OR of fast status bits 1 and up, one clock later.
- R8: The controller never clears a raw bit. Raw follows `src_i` regardless of enables or bus writes, and writes to addresses 0, 1 and 4 change nothing.
- R9: A write to the select register (address 7) stores data bits [4:0]. A read returns that index in bits [4:0] and the raw bit of that source in bit 31. For an index of 20 or more, bit 31 reads as zero.
- R10: After reset, all enables, the select index and both request outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| src_i | input | 20 | Level request lines, one per source position |
| irq_o | output | 1 | Normal request to the core |
| fiq_o | output | 1 | Fast request to the core |

## Verification
Read data is combinational, and so are the status registers with respect to `src_i`. The bench therefore checks `rdata_o` shortly after driving the address in the same cycle, against its model state from before any write in that cycle lands. An enable write takes effect at the next rising edge. A request output reflects the status at that same edge: it is computed from the new `src_i` with the enables as they stood before the write, and the bench compares it at the following falling edge. Stimulus and all checks stay on falling edges, one full half-period away from the edge where the state updates.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DW = 32;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_RAW     = 3'd0,
    A_IRQ_STA = 3'd1,
    A_IRQ_EN  = 3'd2,
    A_IRQ_DIS = 3'd3,
    A_FIQ_STA = 3'd4,
    A_FIQ_EN  = 3'd5,
    A_FIQ_DIS = 3'd6,
    A_SEL     = 3'd7
  } addr_e;

  // positions that may be enabled: 2..n-1 minus the reserved hole
  function automatic logic [DW-1:0] en_mask(int n, int rsv);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 2; i < n; i++) if (i != rsv) m[i] = 1'b1;
    return m;
  endfunction

  // raw view adds the software interrupt position
  function automatic logic [DW-1:0] raw_mask(int n, int rsv);
    logic [DW-1:0] m;
    m = en_mask(n, rsv);
    m[1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqc_path.sv
module irqc_path #(
  parameter int NUM_SRC = 20,
  parameter logic [NUM_SRC-1:0] EN_MASK = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_we_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] raw_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] sta_o,
  output logic               req_o
);
  logic [NUM_SRC-1:0] en_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (EN_MASK[i]) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    en_q[i] <= 1'b0;
        else if (clr_we_i && wdata_i[i]) en_q[i] <= 1'b0;
        else if (set_we_i && wdata_i[i]) en_q[i] <= 1'b1;
      end
    end else begin : g_rsv
      assign en_q[i] = 1'b0;
    end
  end

  assign en_o  = en_q;
  assign sta_o = raw_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= |sta_o;
  end
endmodule

// File: rtl/irqc_rd_mux.sv
module irqc_rd_mux
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 20
) (
  input  logic [AW-1:0]      addr_i,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] irq_sta_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic [NUM_SRC-1:0] fiq_sta_i,
  input  logic [NUM_SRC-1:0] fiq_en_i,
  input  logic [DW-1:0]      sel_word_i,
  output logic [DW-1:0]      rdata_o
);
  localparam int PAD = DW - NUM_SRC;

  always_comb begin
    unique case (addr_e'(addr_i))
      A_RAW:     rdata_o = {{PAD{1'b0}}, raw_i};
      A_IRQ_STA: rdata_o = {{PAD{1'b0}}, irq_sta_i};
      A_IRQ_EN:  rdata_o = {{PAD{1'b0}}, irq_en_i};
      A_FIQ_STA: rdata_o = {{PAD{1'b0}}, fiq_sta_i};
      A_FIQ_EN:  rdata_o = {{PAD{1'b0}}, fiq_en_i};
      A_SEL:     rdata_o = sel_word_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int RSV_BIT = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int SEL_W = 5;
  localparam logic [DW-1:0] EN_M  = en_mask(NUM_SRC, RSV_BIT);
  localparam logic [DW-1:0] RAW_M = raw_mask(NUM_SRC, RSV_BIT);

  logic [NUM_SRC-1:0] raw, irq_sta, irq_en, fiq_sta, fiq_en, fiq_view;
  logic               any_req;
  logic [SEL_W-1:0]   sel_q;
  logic               sel_pend;
  logic [DW-1:0]      sel_word;

  assign raw = src_i & RAW_M[NUM_SRC-1:0];

  irqc_path #(.NUM_SRC(NUM_SRC), .EN_MASK(EN_M[NUM_SRC-1:0])) u_irq (
    .clk_i, .rst_ni,
    .set_we_i (wr_en_i && addr_i == A_IRQ_EN),
    .clr_we_i (wr_en_i && addr_i == A_IRQ_DIS),
    .wdata_i  (wdata_i[NUM_SRC-1:0]),
    .raw_i    (raw),
    .en_o     (irq_en),
    .sta_o    (irq_sta),
    .req_o    (irq_o)
  );

  irqc_path #(.NUM_SRC(NUM_SRC), .EN_MASK(EN_M[NUM_SRC-1:0])) u_fiq (
    .clk_i, .rst_ni,
    .set_we_i (wr_en_i && addr_i == A_FIQ_EN),
    .clr_we_i (wr_en_i && addr_i == A_FIQ_DIS),
    .wdata_i  (wdata_i[NUM_SRC-1:0]),
    .raw_i    (raw),
    .en_o     (fiq_en),
    .sta_o    (fiq_sta),
    .req_o    (fiq_o)
  );

  // fast-path bit 0 summarises both paths
  assign any_req  = |(irq_sta | fiq_sta);
  assign fiq_view = {fiq_sta[NUM_SRC-1:1], any_req};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        sel_q <= '0;
    else if (wr_en_i && addr_i == A_SEL) sel_q <= wdata_i[SEL_W-1:0];
  end

  assign sel_pend = (int'(sel_q) < NUM_SRC) ? raw[sel_q] : 1'b0;
  assign sel_word = {sel_pend, {(DW-SEL_W-1){1'b0}}, sel_q};

  irqc_rd_mux #(.NUM_SRC(NUM_SRC)) u_rd (
    .addr_i,
    .raw_i      (raw),
    .irq_sta_i  (irq_sta),
    .irq_en_i   (irq_en),
    .fiq_sta_i  (fiq_view),
    .fiq_en_i   (fiq_en),
    .sel_word_i (sel_word),
    .rdata_o
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NUM_SRC = 20,
  parameter int RSV_BIT = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [2:0]         addr_i,
  input logic [31:0]        wdata_i,
  input logic [NUM_SRC-1:0] irq_en,
  input logic [NUM_SRC-1:0] fiq_en,
  input logic [NUM_SRC-1:0] irq_sta,
  input logic [NUM_SRC-1:0] fiq_sta,
  input logic [NUM_SRC-1:0] fiq_view,
  input logic               irq_o,
  input logic               fiq_o
);
  localparam logic [31:0] EN_M = irqc_pkg::en_mask(NUM_SRC, RSV_BIT);
  localparam logic [NUM_SRC-1:0] BAD = ~EN_M[NUM_SRC-1:0];

  // R2
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd2) |=>
      ((irq_en & $past(wdata_i[NUM_SRC-1:0]) & EN_M[NUM_SRC-1:0]) == ($past(wdata_i[NUM_SRC-1:0]) & EN_M[NUM_SRC-1:0])));

  // R3
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd6) |=> ((fiq_en & $past(wdata_i[NUM_SRC-1:0])) == '0));

  // R2
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i inside {3'd2, 3'd3, 3'd5, 3'd6}) |=> ($stable(irq_en) && $stable(fiq_en)));

  // R4
  rsv_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_en | fiq_en) & BAD) == '0);

  // R6
  fast_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_view[0] == ((irq_sta | fiq_sta) != '0));

  // R7
  irq_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 irq_o == ($past(irq_sta) != '0));

  // R7
  fiq_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 fiq_o == ($past(fiq_sta) != '0));
endmodule

bind irqc_top irqc_chk #(.NUM_SRC(NUM_SRC), .RSV_BIT(RSV_BIT)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
  .irq_en, .fiq_en, .irq_sta, .fiq_sta, .fiq_view, .irq_o, .fiq_o
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
  localparam int N = 20;
  localparam logic [31:0] EN_M  = 32'h000F_7FFC;
  localparam logic [31:0] RAW_M = 32'h000F_7FFE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] src = '0;
  logic        irq, fiq;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] m_ien = '0, m_fen = '0;
  logic [4:0]  m_sel = '0;
  logic        e_irq = 1'b0, e_fiq = 1'b0;

  irqc_top uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .src_i(src), .irq_o(irq), .fiq_o(fiq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] raw_of(logic [N-1:0] s);
    return {12'b0, s} & RAW_M;
  endfunction

  function automatic logic [31:0] model_rd(logic [2:0] a, logic [N-1:0] s);
    logic [31:0] r, is, fs;
    r  = raw_of(s);
    is = r & m_ien;
    fs = r & m_fen;
    case (a)
      3'd0: return r;
      3'd1: return is;
      3'd2: return m_ien;
      3'd4: return fs | {31'b0, |(is | fs)};
      3'd5: return m_fen;
      3'd7: return {(m_sel < 5'd20) ? r[m_sel] : 1'b0, 26'b0, m_sel};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tag(logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1, 3'd4: return "R5";
      3'd2, 3'd5: return "R2";
      3'd3, 3'd6: return "R3";
      default: return "R9";
    endcase
  endfunction

  // one bus cycle: check outputs, drive, check read, advance model
  task automatic step(logic w, logic [2:0] a, logic [31:0] d, logic [N-1:0] s);
    @(negedge clk);
    chk("R7 irq_o", {31'b0, irq}, {31'b0, e_irq});
    chk("R7 fiq_o", {31'b0, fiq}, {31'b0, e_fiq});
    we = w; addr = a; wdata = d; src = s;
    #1;
    chk(tag(a), rdata, model_rd(a, s));
    e_irq = |(raw_of(s) & m_ien);
    e_fiq = |(raw_of(s) & m_fen);
    if (w) begin
      case (a)
        3'd2: m_ien = m_ien | (d & EN_M);
        3'd3: m_ien = m_ien & ~d;
        3'd5: m_fen = m_fen | (d & EN_M);
        3'd6: m_fen = m_fen & ~d;
        3'd7: m_sel = d[4:0];
        default: ;
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 irq_o", {31'b0, irq}, 32'b0);
    chk("R10 fiq_o", {31'b0, fiq}, 32'b0);
    rst_n = 1'b1;
    addr = 3'd2; #1; chk("R10 irq en", rdata, 32'b0);
    addr = 3'd5; #1; chk("R10 fiq en", rdata, 32'b0);
    addr = 3'd7; #1; chk("R10 sel", rdata, 32'b0);

    // R4 all ones: only legal bits stick
    step(1, 3'd2, 32'hFFFF_FFFF, '0);
    step(0, 3'd2, 0, '0);
    chk("R4 irq en mask", rdata, EN_M);
    // R3 clear half, R2 zeros ignored
    step(1, 3'd3, 32'h0000_00F0, '0);
    step(1, 3'd2, 32'h0, '0);
    step(0, 3'd2, 0, '0);
    chk("R3 irq en after clear", rdata, EN_M & ~32'hF0);
    // R1 bit 0 and 15 invisible, SWI bit 1 visible but not enableable
    step(0, 3'd0, 0, 20'h0_8003);
    chk("R1 raw", rdata, 32'h2);
    step(1, 3'd5, 32'h0000_0002, 20'h0_0002);
    step(0, 3'd4, 0, 20'h0_0002);
    chk("R4 swi fast status", rdata, 32'h0);
    // R8 write to raw ignored
    step(1, 3'd0, 32'hFFFF_FFFF, 20'h0_0400);
    step(0, 3'd0, 0, 20'h0_0400);
    chk("R8 raw follows src", rdata, 32'h400);
    // R6 summary bit via normal path only
    step(0, 3'd4, 0, 20'h0_0400);
    chk("R6 fast bit0", rdata, 32'h1);
    // R9 out-of-range select
    step(1, 3'd7, 32'd25, 20'hF_FFFF);
    step(0, 3'd7, 0, 20'hF_FFFF);
    chk("R9 sel oob", rdata, 32'd25);
    step(1, 3'd7, 32'd10, 20'h0_0400);
    step(0, 3'd7, 0, 20'h0_0400);
    chk("R9 sel pend", rdata, 32'h8000_000A);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      logic [N-1:0] s;
      a = 3'($urandom_range(0, 7));
      d = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 31)) : $urandom;
      s = ($urandom_range(0, 2) == 0) ? '0 : N'($urandom & $urandom);
      step($urandom_range(0, 1) == 1, a, d, s);
    end
    step(0, 3'd0, 0, '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule